// File: doc/BRIEF.md
# Display Mode Register Bank

This block is the register file a linear-framebuffer display controller exposes to its host bus. It has two windows. The mode window is a set of 16-bit registers, selected by the byte address shifted right by one, that hold the scan-out geometry: enable, pixel depth, horizontal and vertical resolution, virtual line width and the two panning offsets. Two of its indices do not read from storage. One returns a fixed controller version code. The other returns the size of the video memory in 64 KiB units.

The second window is small and holds the framebuffer byte-order control. It changes only when one of two exact magic words is written to it, and it also reports its own size. The stored mode fields are driven continuously to the scan-out logic, together with the byte-order flag.

The bus is a simple single-cycle slave bus. A request is taken on every clock where `req_i` is high. Writes take effect at that edge. Read data is registered and appears one cycle later, marked by `rvalid_o`. Reset is asserted asynchronously and released in step with the clock.

Top module: `dmr_regfile`

## Requirements
- R1: After reset, every stored mode register reads zero, every mode output is zero, the byte order is little-endian, `rvalid_o` is low and `rdata_o` is zero.
- R2: A mode-window write to a storing index keeps all 16 bits of `wdata_i[15:0]` with no masking. A later read of that index returns the value in `rdata_o[15:0]`, and bits 31:16 are zero.
- R3: A read of mode index 0 returns 0x0000B0C5, whatever was written to that index.
- R4: A read of mode index 10 returns the memory size in 64 KiB units. `MEM_BYTES` is first rounded up to a power of two and clamped to the range 4 MiB to 256 MiB. The default of 16 MiB reads 0x0100, and 5 MiB reads 0x0080.
- R5: A read of a mode index of 11 or above returns 0x0000FFFF.
- R6: A write to a mode index of 11 or above changes no register and no output.
- R7: The mode outputs follow the stored registers at these indices: resolution x at 1, y at 2, bits per pixel at 3, enable at 4, virtual width at 6, x offset at 8, y offset at 9. Indices 5 and 7 store values but drive no output.
- R8: The byte-order register sits at extended offset 4. Writing 0xBEBEBEBE selects big-endian, and writing 0x1E1E1E1E selects little-endian. Reading the register returns the magic word of the current mode. Any other written value leaves the mode unchanged.
- R9: Extended offset 0 reads 0x00000008, the window size. Every other extended offset except 4 reads zero.
- R10: An extended-window access with `size_i` other than 2'b10 (32-bit) is ignored. Its writes are dropped and its reads return zero.
- R11: Byte address bit 0 is ignored in the mode window, so an odd address selects the same register as the even address below it.
- R12: `rvalid_o` is high in exactly the cycle after a read request. Writes and idle cycles never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| ext_sel_i | input | 1 | 0 = mode window, 1 = extended window |
| size_i | input | 2 | Access size: 2'b01 = 16-bit, 2'b10 = 32-bit |
| addr_i | input | ADDR_W | Byte address within the selected window |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| mode_enable_o | output | 16 | Enable register |
| mode_bpp_o | output | 16 | Bits-per-pixel register |
| mode_xres_o | output | 16 | Horizontal resolution |
| mode_yres_o | output | 16 | Vertical resolution |
| mode_vwidth_o | output | 16 | Virtual line width |
| mode_xoff_o | output | 16 | Horizontal offset |
| mode_yoff_o | output | 16 | Vertical offset |
| fb_big_endian_o | output | 1 | 1 = big-endian framebuffer |

## Verification
Two things can meet in one cycle. A read response is still leaving the output register while the next request, a write, is already updating a register or the byte-order flag. The reverse also happens: a write is followed at once by a read of the same location, which must return the new value. Directed back-to-back sequences provoke both orders, and a long stream of random accesses mixes windows, sizes, out-of-range indices and magic words. A behavioural model in the bench predicts `rvalid_o`, `rdata_o`, every mode output and the byte-order flag, and every clock is compared against it.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  localparam int REG_W     = 16;
  localparam int MODE_REGS = 11;

  // Mode window indices whose position the scan-out side decodes
  localparam int IDX_ID     = 0;
  localparam int IDX_XRES   = 1;
  localparam int IDX_YRES   = 2;
  localparam int IDX_BPP    = 3;
  localparam int IDX_ENABLE = 4;
  localparam int IDX_VWIDTH = 6;
  localparam int IDX_XOFF   = 8;
  localparam int IDX_YOFF   = 9;
  localparam int IDX_MEM    = 10;

  localparam logic [REG_W-1:0] ID_VALUE = 16'hB0C5;

  // Extended window
  localparam int          EXT_OFF_SIZE     = 0;
  localparam int          EXT_OFF_ORDER    = 4;
  localparam logic [31:0] EXT_WINDOW_BYTES = 32'd8;
  localparam logic [31:0] ORDER_BIG        = 32'hBEBEBEBE;
  localparam logic [31:0] ORDER_LITTLE     = 32'h1E1E1E1E;
  localparam logic [1:0]  SIZE_WORD        = 2'b10;

  typedef struct packed {
    logic [REG_W-1:0] enable;
    logic [REG_W-1:0] bpp;
    logic [REG_W-1:0] xres;
    logic [REG_W-1:0] yres;
    logic [REG_W-1:0] vwidth;
    logic [REG_W-1:0] xoff;
    logic [REG_W-1:0] yoff;
  } mode_view_t;

  // Round up to a power of two inside [4 MiB, 256 MiB], report in 64 KiB units
  function automatic logic [REG_W-1:0] mem_units(input longint bytes);
    longint p;
    p = 64'd4194304;
    for (int i = 0; i < 6; i++) begin
      if (p < bytes) p = p * 2;
    end
    return REG_W'(p >> 16);
  endfunction

endpackage

// File: rtl/dmr_rst_sync.sv
module dmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/dmr_mode_bank.sv
module dmr_mode_bank
  import dmr_pkg::*;
#(
  parameter int               IDX_W     = 7,
  parameter logic [REG_W-1:0] MEM_UNITS = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data,
  output mode_view_t       view
);
  localparam int FLAT_W = MODE_REGS * REG_W;

  logic [FLAT_W-1:0] bank_flat;

  for (genvar g = 0; g < MODE_REGS; g++) begin : g_slot
    if (g == IDX_ID || g == IDX_MEM) begin : g_const
      // computed on read, no storage
      assign bank_flat[g*REG_W +: REG_W] = '0;
    end else begin : g_store
      logic             hit;
      logic [REG_W-1:0] slot_d;
      logic [REG_W-1:0] slot_q;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_comb begin
        slot_d = slot_q;
        if (hit) slot_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
      end

      assign bank_flat[g*REG_W +: REG_W] = slot_q;
    end
  end

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < MODE_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = bank_flat[i*REG_W +: REG_W];
    end
    if (rd_idx == IDX_W'(IDX_ID))  rd_data = ID_VALUE;
    if (rd_idx == IDX_W'(IDX_MEM)) rd_data = MEM_UNITS;
  end

  assign view.enable = bank_flat[IDX_ENABLE*REG_W +: REG_W];
  assign view.bpp    = bank_flat[IDX_BPP*REG_W    +: REG_W];
  assign view.xres   = bank_flat[IDX_XRES*REG_W   +: REG_W];
  assign view.yres   = bank_flat[IDX_YRES*REG_W   +: REG_W];
  assign view.vwidth = bank_flat[IDX_VWIDTH*REG_W +: REG_W];
  assign view.xoff   = bank_flat[IDX_XOFF*REG_W   +: REG_W];
  assign view.yoff   = bank_flat[IDX_YOFF*REG_W   +: REG_W];
endmodule

// File: rtl/dmr_ext_regs.sv
module dmr_ext_regs
  import dmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              word_ok,
  input  logic [ADDR_W-1:0] offset,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              big_endian
);
  logic at_order;
  logic at_size;
  logic be_d;
  logic be_q;

  assign at_order = (offset == ADDR_W'(EXT_OFF_ORDER));
  assign at_size  = (offset == ADDR_W'(EXT_OFF_SIZE));

  always_comb begin
    be_d = be_q;
    if (wr_en && word_ok && at_order) begin
      if (wr_data == ORDER_BIG)         be_d = 1'b1;
      else if (wr_data == ORDER_LITTLE) be_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_q <= 1'b0;
    else        be_q <= be_d;
  end

  always_comb begin
    rd_data = '0;
    if (word_ok) begin
      if (at_size)  rd_data = EXT_WINDOW_BYTES;
      if (at_order) rd_data = be_q ? ORDER_BIG : ORDER_LITTLE;
    end
  end

  assign big_endian = be_q;
endmodule

// File: rtl/dmr_regfile.sv
module dmr_regfile
  import dmr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_BYTES = 16777216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ext_sel_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic [15:0]       mode_enable_o,
  output logic [15:0]       mode_bpp_o,
  output logic [15:0]       mode_xres_o,
  output logic [15:0]       mode_yres_o,
  output logic [15:0]       mode_vwidth_o,
  output logic [15:0]       mode_xoff_o,
  output logic [15:0]       mode_yoff_o,
  output logic              fb_big_endian_o
);
  localparam int               IDX_W     = ADDR_W - 1;
  localparam logic [REG_W-1:0] MEM_UNITS = mem_units(longint'(MEM_BYTES));

  logic             srst_n;
  logic             mode_wr;
  logic             ext_wr;
  logic             rd_req;
  logic             word_ok;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] mode_rd;
  logic [31:0]      ext_rd;
  logic [31:0]      rsp_sel;
  mode_view_t       view;

  logic             rvalid_d, rvalid_q;
  logic [31:0]      rdata_d,  rdata_q;

  dmr_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign idx     = addr_i[ADDR_W-1:1];
  assign word_ok = (size_i == SIZE_WORD);
  assign mode_wr = req_i && we_i && !ext_sel_i;
  assign ext_wr  = req_i && we_i && ext_sel_i;
  assign rd_req  = req_i && !we_i;

  dmr_mode_bank #(
    .IDX_W     (IDX_W),
    .MEM_UNITS (MEM_UNITS)
  ) i_mode_bank (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (mode_wr),
    .wr_idx  (idx),
    .wr_data (wdata_i[REG_W-1:0]),
    .rd_idx  (idx),
    .rd_data (mode_rd),
    .view    (view)
  );

  dmr_ext_regs #(
    .ADDR_W (ADDR_W)
  ) i_ext_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (ext_wr),
    .word_ok    (word_ok),
    .offset     (addr_i),
    .wr_data    (wdata_i),
    .rd_data    (ext_rd),
    .big_endian (fb_big_endian_o)
  );

  assign rsp_sel = ext_sel_i ? ext_rd : {16'h0000, mode_rd};

  always_comb begin
    rvalid_d = rd_req;
    rdata_d  = rdata_q;
    if (rd_req) rdata_d = rsp_sel;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rvalid_o      = rvalid_q;
  assign rdata_o       = rdata_q;
  assign mode_enable_o = view.enable;
  assign mode_bpp_o    = view.bpp;
  assign mode_xres_o   = view.xres;
  assign mode_yres_o   = view.yres;
  assign mode_vwidth_o = view.vwidth;
  assign mode_xoff_o   = view.xoff;
  assign mode_yoff_o   = view.yoff;
endmodule

// File: rtl/dmr_regfile_chk.sv
module dmr_regfile_chk
  import dmr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] MEM_UNITS = 16'h0100
) (
  input logic              clk,
  input logic              srst_n,
  input logic              req_i,
  input logic              we_i,
  input logic              ext_sel_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rvalid_o,
  input logic [31:0]       rdata_o,
  input logic [15:0]       mode_enable_o,
  input logic [15:0]       mode_bpp_o,
  input logic [15:0]       mode_xres_o,
  input logic              fb_big_endian_o
);
  logic             rd_mode, rd_ext, wr_mode;
  logic [ADDR_W-2:0] c_idx;
  logic             order_hit;

  assign c_idx     = addr_i[ADDR_W-1:1];
  assign rd_mode   = req_i && !we_i && !ext_sel_i;
  assign rd_ext    = req_i && !we_i && ext_sel_i;
  assign wr_mode   = req_i && we_i && !ext_sel_i;
  assign order_hit = req_i && we_i && ext_sel_i && (size_i == SIZE_WORD) &&
                     (addr_i == ADDR_W'(EXT_OFF_ORDER)) &&
                     ((wdata_i == ORDER_BIG) || (wdata_i == ORDER_LITTLE));

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (req_i && !we_i) |=> rvalid_o);                                        // R12
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!srst_n)
    !(req_i && !we_i) |=> !rvalid_o);                                      // R12
  AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_mode && c_idx == '0) |=> (rdata_o == {16'h0000, ID_VALUE}));       // R3
  AST_MEM_UNITS: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_mode && c_idx == (ADDR_W-1)'(IDX_MEM)) |=> (rdata_o == {16'h0000, MEM_UNITS})); // R4
  AST_OOR_READ_ONES: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_mode && c_idx >= (ADDR_W-1)'(MODE_REGS)) |=> (rdata_o == 32'h0000FFFF)); // R5
  AST_OOR_WRITE_DROP: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_mode && c_idx >= (ADDR_W-1)'(MODE_REGS)) |=>
    ($stable(mode_enable_o) && $stable(mode_bpp_o) && $stable(mode_xres_o))); // R6
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !(wr_mode && c_idx == (ADDR_W-1)'(IDX_ENABLE)) |=> $stable(mode_enable_o)); // R7
  AST_ORDER_MAGIC_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    !order_hit |=> $stable(fb_big_endian_o));                              // R8
  AST_EXT_NARROW_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_ext && size_i != SIZE_WORD) |=> (rdata_o == 32'h0));               // R10
endmodule

bind dmr_regfile dmr_regfile_chk #(
  .ADDR_W    (ADDR_W),
  .MEM_UNITS (MEM_UNITS)
) i_dmr_chk (
  .clk             (clk),
  .srst_n          (srst_n),
  .req_i           (req_i),
  .we_i            (we_i),
  .ext_sel_i       (ext_sel_i),
  .size_i          (size_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .rvalid_o        (rvalid_o),
  .rdata_o         (rdata_o),
  .mode_enable_o   (mode_enable_o),
  .mode_bpp_o      (mode_bpp_o),
  .mode_xres_o     (mode_xres_o),
  .fb_big_endian_o (fb_big_endian_o)
);

// File: tb/test_dmr_regfile.sv
`timescale 1ns/1ps
module test_dmr_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, ext;
  logic [1:0]  size;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        rvalid, rvalid_b;
  logic [31:0] rdata, rdata_b;
  logic [15:0] en_o, bpp_o, xres_o, yres_o, vw_o, xoff_o, yoff_o;
  logic [15:0] d_en, d_bpp, d_xres, d_yres, d_vw, d_xoff, d_yoff;
  logic        be_o, d_be;

  int checks   = 0;
  int failures = 0;
  int m_regs [0:10];
  bit m_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmr_regfile #(.ADDR_W(ADDR_W)) i_dmr_regfile (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .ext_sel_i(ext),
    .size_i(size), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata),
    .mode_enable_o(en_o), .mode_bpp_o(bpp_o), .mode_xres_o(xres_o),
    .mode_yres_o(yres_o), .mode_vwidth_o(vw_o), .mode_xoff_o(xoff_o),
    .mode_yoff_o(yoff_o), .fb_big_endian_o(be_o));

  // second instance: 5 MiB rounds up to 8 MiB
  dmr_regfile #(.ADDR_W(ADDR_W), .MEM_BYTES(5242880)) i_dmr_regfile_odd (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .ext_sel_i(ext),
    .size_i(size), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid_b), .rdata_o(rdata_b),
    .mode_enable_o(d_en), .mode_bpp_o(d_bpp), .mode_xres_o(d_xres),
    .mode_yres_o(d_yres), .mode_vwidth_o(d_vw), .mode_xoff_o(d_xoff),
    .mode_yoff_o(d_yoff), .fb_big_endian_o(d_be));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input bit x, input logic [1:0] sz, input int a);
    int i;
    if (x) begin
      if (sz != 2'b10) return 32'h0;
      if (a == 0) return 32'h8;
      if (a == 4) return m_be ? 32'hBEBEBEBE : 32'h1E1E1E1E;
      return 32'h0;
    end
    i = a >> 1;
    if (i == 0)  return 32'h0000B0C5;
    if (i == 10) return 32'h00000100;
    if (i >= 11) return 32'h0000FFFF;
    return 32'(m_regs[i]);
  endfunction

  task automatic model_write(input bit x, input logic [1:0] sz, input int a, input logic [31:0] d);
    int i;
    if (x) begin
      if (sz == 2'b10 && a == 4) begin
        if (d == 32'hBEBEBEBE) m_be = 1'b1;
        else if (d == 32'h1E1E1E1E) m_be = 1'b0;
      end
    end else begin
      i = a >> 1;
      if (i < 11) m_regs[i] = int'(d[15:0]);
    end
  endtask

  // called at a negedge: drive, let one edge pass, compare at next negedge
  task automatic op(input bit r, input bit w, input bit x, input logic [1:0] sz,
                    input int a, input logic [31:0] d, input string tag);
    bit exp_rv;
    logic [31:0] exp_rd;
    req = r; we = w; ext = x; size = sz; addr = 8'(a); wdata = d;
    @(posedge clk);
    exp_rv = r && !w;
    exp_rd = model_read(x, sz, a);
    if (r && w) model_write(x, sz, a, d);
    @(negedge clk);
    chk("R12", "rvalid", 32'(rvalid), 32'(exp_rv));
    if (exp_rv) chk(tag, "rdata", rdata, exp_rd);
    if (exp_rv && !x && (a >> 1) == 10) chk("R4", "rdata_5MiB", rdata_b, 32'h80);
    chk("R7", "enable", 32'(en_o),   32'(m_regs[4][15:0]));
    chk("R7", "bpp",    32'(bpp_o),  32'(m_regs[3][15:0]));
    chk("R7", "xres",   32'(xres_o), 32'(m_regs[1][15:0]));
    chk("R7", "yres",   32'(yres_o), 32'(m_regs[2][15:0]));
    chk("R7", "vwidth", 32'(vw_o),   32'(m_regs[6][15:0]));
    chk("R7", "xoff",   32'(xoff_o), 32'(m_regs[8][15:0]));
    chk("R7", "yoff",   32'(yoff_o), 32'(m_regs[9][15:0]));
    chk("R8", "big_endian", 32'(be_o), 32'(m_be));
  endtask

  task automatic mwr(input int a, input logic [31:0] d, input string tag);
    op(1'b1, 1'b1, 1'b0, 2'b01, a, d, tag);
  endtask
  task automatic mrd(input int a, input string tag);
    op(1'b1, 1'b0, 1'b0, 2'b01, a, 32'h0, tag);
  endtask
  task automatic xwr(input int a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    op(1'b1, 1'b1, 1'b1, sz, a, d, tag);
  endtask
  task automatic xrd(input int a, input logic [1:0] sz, input string tag);
    op(1'b1, 1'b0, 1'b1, sz, a, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 11; i++) m_regs[i] = 0;
    m_be = 1'b0;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; ext = 1'b0;
    size = 2'b01; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "rvalid", 32'(rvalid), 32'h0);
    chk("R1", "rdata", rdata, 32'h0);
    chk("R1", "enable", 32'(en_o), 32'h0);
    chk("R1", "xres", 32'(xres_o), 32'h0);
    chk("R1", "big_endian", 32'(be_o), 32'h0);
    xrd(4, 2'b10, "R1");
    for (int i = 1; i < 10; i++) mrd(2*i, "R1");

    // R2 / R11: full-width store, odd address aliasing
    mwr(2, 32'hDEAD_0400, "R2");
    mrd(2, "R2");
    mwr(3, 32'h0000_FFFF, "R11");
    mrd(2, "R11");
    mrd(3, "R11");
    for (int i = 0; i < 11; i++) mwr(2*i, 32'(16'hA500 + 16'(i * 16'h0111)), "R2");
    for (int i = 0; i < 11; i++) mrd(2*i, "R2");
    mrd(0, "R3");
    mrd(1, "R3");
    mrd(20, "R4");
    mrd(21, "R4");

    // R5 / R6: out-of-range indices
    mrd(22, "R5");
    mrd(100, "R5");
    mrd(255, "R5");
    mwr(22, 32'h1111, "R6");
    mwr(101, 32'h2222, "R6");
    mwr(254, 32'h3333, "R6");
    for (int i = 1; i < 10; i++) mrd(2*i, "R6");

    // R7: geometry
    mwr(8, 32'h0001, "R7");
    mwr(6, 32'h0020, "R7");
    mwr(12, 32'h0500, "R7");
    mwr(18, 32'h0007, "R7");

    // R8: byte order
    xwr(4, 2'b10, 32'hBEBEBEBE, "R8");
    xrd(4, 2'b10, "R8");
    xwr(4, 2'b10, 32'h12345678, "R8");
    xrd(4, 2'b10, "R8");
    xwr(4, 2'b10, 32'h1E1E1E1F, "R8");
    xwr(0, 2'b10, 32'h1E1E1E1E, "R8");
    xrd(4, 2'b10, "R8");
    xwr(4, 2'b10, 32'h1E1E1E1E, "R8");
    xrd(4, 2'b10, "R8");

    // R9: size register and empty offsets
    xrd(0, 2'b10, "R9");
    xrd(8, 2'b10, "R9");
    xrd(12, 2'b10, "R9");
    xrd(5, 2'b10, "R9");

    // R10: narrow accesses on the extended window
    xwr(4, 2'b01, 32'hBEBEBEBE, "R10");
    xrd(4, 2'b10, "R10");
    xrd(4, 2'b01, "R10");
    xrd(0, 2'b00, "R10");

    // back-to-back: write then read same location, read then write
    mwr(16, 32'h0ABC, "R2");
    mrd(16, "R2");
    mrd(16, "R2");
    mwr(16, 32'h0DEF, "R2");
    xwr(4, 2'b10, 32'hBEBEBEBE, "R8");
    xrd(4, 2'b10, "R8");
    op(1'b0, 1'b0, 1'b0, 2'b01, 0, 32'h0, "R12");
    op(1'b0, 1'b1, 1'b1, 2'b10, 4, 32'h1E1E1E1E, "R12");

    // mixed random traffic
    for (int n = 0; n < 1500; n++) begin
      bit          r, w, x;
      logic [1:0]  sz;
      int          a;
      logic [31:0] d;
      int          pick;
      r    = ($urandom % 8) != 0;
      w    = $urandom % 2;
      x    = ($urandom % 3) == 0;
      sz   = 2'($urandom % 4);
      if (x && ($urandom % 2)) sz = 2'b10;
      a    = x ? int'($urandom % 16) : int'($urandom % 40);
      if (($urandom % 10) == 0) a = int'($urandom % 256);
      pick = int'($urandom % 4);
      d    = (pick == 0) ? 32'hBEBEBEBE : (pick == 1) ? 32'h1E1E1E1E : $urandom;
      op(r, w, x, sz, a, d, x ? "R9" : "R2");
    end

    op(1'b0, 1'b0, 1'b0, 2'b01, 0, 32'h0, "R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule